// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a flash memory model. It watches the bus write cycles presented to the memory, each one an address, a data word and a one-cycle strobe, and recognises the multi-cycle unlock grammar. Every command in that grammar opens with two unlock writes. The recognised commands are reset to array read, identifier read, single program, entry to a persistent bypass mode, the short bypass program, bypass exit, chip erase, sector erase, and erase suspend and resume.

When a command completes, the block raises a one-cycle request carrying an operation code, together with the address and data of the write that completed it. The program engine, the erase engine and the status logic sit outside this block. They report the end of their work on a single done input. The block also tells the read path which source to use: the array, the identifier registers or the status word. In identifier mode it forms the identifier word itself.

Addressing is either byte-wide or word-wide, picked by one input. The unlock addresses change with that choice. In bypass mode a program takes only two writes, and the mode stays in force until a dedicated two-write exit.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, no request is pending and rd_src reads 0 (array). Asserting rst_n aborts any operation in progress and returns rd_src to 0 at once.
- R2: Unlock and command addresses compare only the low bits: 12 bits in byte mode (byte_mode=1), where the writes go to AAAh, 555h, then AAAh; 11 bits in word mode, where they go to 555h, 2AAh, then 555h. wr_data[15:8] is ignored on every unlock and command write.
- R3: In array or identifier mode, a write whose low byte is F0h, at any address and at any point of a sequence other than the program-data write, issues a request with op 0 (reset) and sets rd_src to 0.
- R4: Two unlocks, then A0h, then a fourth write issue a request with op 1 (program) carrying the fourth write's address and data. rd_src becomes 2 (status) in the same cycle.
- R5: Two unlocks followed by 20h enter bypass mode. In bypass mode, A0h followed by any write issues a program request (op 1), and this can repeat.
- R6: In bypass mode, every write other than the A0h program pair and the 90h/00h exit pair is ignored, F0h included. A write of 90h followed by a write of 00h returns the decoder to array read.
- R7: Two unlocks followed by 90h set rd_src to 1 (identifier). id_rdata decodes an offset, taken from rd_offs[1:0] in word mode and from rd_offs[2:1] in byte mode. Offset 0 gives the maker code 0052h. Offset 1 gives the device code 22DAh, cut to its low byte in byte mode. Offset 2 gives 0001h when sect_prot=1 and 0000h otherwise.
- R8: While a program or erase runs (rd_src=2), writes issue no request, except B0h during an erase. op_done ends the run: after a bypass program the decoder returns to bypass mode, and otherwise it returns to array read.
- R9: A write that breaks an expected unlock or command pattern issues no request and leaves the decoder in array read.
- R10: Two unlocks, 80h and two more unlocks, followed by 10h at the first unlock address, issue op 2 (chip erase). Followed instead by 30h at any address, they issue op 3 (sector erase) with that address. Either way rd_src becomes 2.
- R11: During an erase, B0h issues op 4 (suspend) and rd_src returns to 0. While suspended, 30h issues op 5 (resume) and rd_src goes back to 2.
- R12: A request is high for exactly one cycle: the cycle after the clock edge that samples the completing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte addressing, 0 selects word addressing |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| op_done | input | 1 | The running program or erase has finished |
| rd_offs | input | 3 | Low read address bits, used for the identifier offset |
| sect_prot | input | 1 | Protection flag of the sector being read |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 3 | 0 reset, 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| req_addr | output | AW | Address latched with the request |
| req_data | output | DW | Data latched with the request |
| rd_src | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_rdata | output | DW | Identifier word for the current offset |

## Verification
The hardest state to reach from the ports is an erase resumed after a suspend, and the bypass mode surviving both a completed program and a stray F0h. Getting there needs long, exactly ordered write chains in which each step relies on the mode the previous command left behind. The stimulus table chains these commands back to back. Each completion pulse sits in the table as a row of its own, and a further bypass program right after the F0h shows that the mode persisted.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_PROG   = 3'd1,
    OP_CHIP   = 3'd2,
    OP_SECT   = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_ID     = 2'd1,
    SRC_STATUS = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    MD_ARRAY, MD_ID, MD_BYP, MD_PROG, MD_ERASE, MD_SUSP
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PA, ST_E1, ST_E2, ST_E3, ST_BP, ST_BX
  } step_e;

  localparam logic [7:0] CMD_UNLK1    = 8'hAA;
  localparam logic [7:0] CMD_UNLK2    = 8'h55;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_PROG     = 8'hA0;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_BYP_EXIT1 = 8'h90;
  localparam logic [7:0] CMD_BYP_EXIT2 = 8'h00;

endpackage

// File: rtl/flash_unlock_match.sv
module flash_unlock_match #(
  parameter int KW = 12
) (
  input  logic          byte_mode,
  input  logic [KW-1:0] key_addr,
  output logic          hit_a,
  output logic          hit_b
);

  // hit_a: first unlock / command address, hit_b: second unlock address
  always_comb begin
    if (byte_mode) begin
      hit_a = (key_addr == KW'(12'hAAA));
      hit_b = (key_addr == KW'(12'h555));
    end else begin
      hit_a = (key_addr[KW-2:0] == (KW-1)'(11'h555));
      hit_b = (key_addr[KW-2:0] == (KW-1)'(11'h2AA));
    end
  end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hit_a,
  input  logic          hit_b,
  input  logic          op_done,
  output logic          req_valid,
  output op_e           req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output mode_e         mode
);

  mode_e mode_q, mode_d, ret_q, ret_d;
  step_e step_q, step_d;
  logic  issue, susp, brk;
  op_e   iop;
  logic [7:0] cmd;

  assign cmd  = wr_data[7:0];
  assign mode = mode_q;

  always_comb begin
    mode_d = mode_q;
    step_d = step_q;
    ret_d  = ret_q;
    issue  = 1'b0;
    iop    = OP_RESET;
    susp   = (mode_q == MD_SUSP);
    brk    = 1'b0;
    case (mode_q)
      MD_PROG: begin
        step_d = ST_IDLE;
        if (op_done) mode_d = ret_q;
      end
      MD_ERASE: begin
        step_d = ST_IDLE;
        if (op_done) begin
          mode_d = MD_ARRAY;
        end else if (wr_en && cmd == CMD_SUSPEND) begin
          mode_d = MD_SUSP;
          issue  = 1'b1;
          iop    = OP_SUSP;
        end
      end
      MD_BYP: begin
        if (wr_en) begin
          case (step_q)
            ST_BP: begin
              issue  = 1'b1;
              iop    = OP_PROG;
              ret_d  = MD_BYP;
              mode_d = MD_PROG;
              step_d = ST_IDLE;
            end
            ST_BX: begin
              step_d = ST_IDLE;
              if (cmd == CMD_BYP_EXIT2) mode_d = MD_ARRAY;
            end
            default: begin
              if (cmd == CMD_PROG)           step_d = ST_BP;
              else if (cmd == CMD_BYP_EXIT1) step_d = ST_BX;
              else                           step_d = ST_IDLE;
            end
          endcase
        end
      end
      default: begin
        if (wr_en) begin
          if (cmd == CMD_RESET && step_q != ST_PA && !susp) begin
            issue  = 1'b1;
            iop    = OP_RESET;
            mode_d = MD_ARRAY;
            step_d = ST_IDLE;
          end else begin
            case (step_q)
              ST_IDLE: begin
                if (cmd == CMD_UNLK1 && hit_a) begin
                  step_d = ST_U1;
                end else if (susp && cmd == CMD_SECTOR) begin
                  issue  = 1'b1;
                  iop    = OP_RESUME;
                  mode_d = MD_ERASE;
                end else begin
                  brk = 1'b1;
                end
              end
              ST_U1: begin
                if (cmd == CMD_UNLK2 && hit_b) step_d = ST_U2;
                else                           brk = 1'b1;
              end
              ST_U2: begin
                step_d = ST_IDLE;
                if (!hit_a)                brk = 1'b1;
                else if (cmd == CMD_PROG)  step_d = ST_PA;
                else if (susp)             brk = 1'b1;
                else begin
                  case (cmd)
                    CMD_IDENT:  mode_d = MD_ID;
                    CMD_BYPASS: mode_d = MD_BYP;
                    CMD_ERASE:  step_d = ST_E1;
                    default:    brk = 1'b1;
                  endcase
                end
              end
              ST_PA: begin
                issue  = 1'b1;
                iop    = OP_PROG;
                ret_d  = susp ? MD_SUSP : MD_ARRAY;
                mode_d = MD_PROG;
                step_d = ST_IDLE;
              end
              ST_E1: begin
                if (cmd == CMD_UNLK1 && hit_a) step_d = ST_E2;
                else                           brk = 1'b1;
              end
              ST_E2: begin
                if (cmd == CMD_UNLK2 && hit_b) step_d = ST_E3;
                else                           brk = 1'b1;
              end
              ST_E3: begin
                step_d = ST_IDLE;
                if (cmd == CMD_CHIP && hit_a) begin
                  issue  = 1'b1;
                  iop    = OP_CHIP;
                  mode_d = MD_ERASE;
                end else if (cmd == CMD_SECTOR) begin
                  issue  = 1'b1;
                  iop    = OP_SECT;
                  mode_d = MD_ERASE;
                end else begin
                  brk = 1'b1;
                end
              end
              default: brk = 1'b1;
            endcase
            if (brk) begin
              step_d = ST_IDLE;
              if (!susp) mode_d = MD_ARRAY;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_ARRAY;
      step_q    <= ST_IDLE;
      ret_q     <= MD_ARRAY;
      req_valid <= 1'b0;
      req_op    <= OP_RESET;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      mode_q    <= mode_d;
      step_q    <= step_d;
      ret_q     <= ret_d;
      req_valid <= issue;
      if (issue) begin
        req_op   <= iop;
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int          DW       = 16,
  parameter logic [15:0] MFR_CODE = 16'h0052,
  parameter logic [15:0] DEV_CODE = 16'h22DA
) (
  input  mode_e         mode,
  input  logic          byte_mode,
  input  logic [2:0]    rd_offs,
  input  logic          sect_prot,
  output src_e          rd_src,
  output logic [DW-1:0] id_rdata
);

  localparam logic [DW-1:0] LOW_MASK = DW'(16'h00FF);
  localparam logic [DW-1:0] MFR_W    = DW'(MFR_CODE);
  localparam logic [DW-1:0] DEV_W    = DW'(DEV_CODE);

  logic [1:0] offs;
  assign offs = byte_mode ? rd_offs[2:1] : rd_offs[1:0];

  always_comb begin
    case (mode)
      MD_PROG, MD_ERASE: rd_src = SRC_STATUS;
      MD_ID:             rd_src = SRC_ID;
      default:           rd_src = SRC_ARRAY;
    endcase
  end

  always_comb begin
    case (offs)
      2'd0:    id_rdata = byte_mode ? (MFR_W & LOW_MASK) : MFR_W;
      2'd1:    id_rdata = byte_mode ? (DEV_W & LOW_MASK) : DEV_W;
      2'd2:    id_rdata = {{(DW-1){1'b0}}, sect_prot};
      default: id_rdata = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          AW       = 20,
  parameter int          DW       = 16,
  parameter logic [15:0] MFR_CODE = 16'h0052,
  parameter logic [15:0] DEV_CODE = 16'h22DA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          op_done,
  input  logic [2:0]    rd_offs,
  input  logic          sect_prot,
  output logic          req_valid,
  output logic [2:0]    req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic [1:0]    rd_src,
  output logic [DW-1:0] id_rdata
);

  localparam int KW = 12;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       hit_a, hit_b;
  mode_e      mode;
  op_e        op_int;
  src_e       src_int;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  flash_unlock_match #(.KW(KW)) u_match (
    .byte_mode (byte_mode),
    .key_addr  (wr_addr[KW-1:0]),
    .hit_a     (hit_a),
    .hit_b     (hit_b)
  );

  flash_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .op_done   (op_done),
    .req_valid (req_valid),
    .req_op    (op_int),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .mode      (mode)
  );

  flash_read_mux #(.DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rmux (
    .mode      (mode),
    .byte_mode (byte_mode),
    .rd_offs   (rd_offs),
    .sect_prot (sect_prot),
    .rd_src    (src_int),
    .id_rdata  (id_rdata)
  );

  assign req_op = op_int;
  assign rd_src = src_int;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          op_done,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_data,
  input logic [1:0]    rd_src
);

  // R12: a request only follows a sampled write
  assert_req_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wr_en));

  // R4: program request carries the completing write
  assert_prog_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1) |-> (req_addr == $past(wr_addr) && req_data == $past(wr_data)));

  // R8: writes during a busy run raise nothing except suspend
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src == 2'd2 && !op_done && wr_en && wr_data[7:0] != 8'hB0) |=> !req_valid);

  // R10: work-starting requests switch reads to status
  assert_status_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd3 || req_op == 3'd5))
      |-> rd_src == 2'd2);

  // R3: a reset request leaves reads on the array
  assert_reset_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd0) |-> rd_src == 2'd0);

  // R11: a suspend request hands reads back to the array
  assert_suspend_array_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |-> rd_src == 2'd0);

  // R7: read source never takes the unused code
  always_comb begin
    if (rst_n) begin
      assert_src_legal_R7: assert (rd_src != 2'd3);
    end
  end

endmodule

bind flash_cmd_decoder flash_cmd_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .op_done   (op_done),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .req_data  (req_data),
  .rd_src    (rd_src)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic          wr;
    logic          dn;
    logic          bm;
    logic [19:0]   a;
    logic [15:0]   d;
    logic          rq;
    logic [2:0]    op;
    logic [1:0]    src;
    logic [3:0]    tag;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    // R4 normal program in word mode, R2 word unlock addresses
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd0,4'd2},
    '{1'b1,1'b0,1'b0,20'h002AA,16'h0055,1'b0,3'd0,2'd0,4'd2},
    '{1'b1,1'b0,1'b0,20'h00555,16'h00A0,1'b0,3'd0,2'd0,4'd4},
    '{1'b1,1'b0,1'b0,20'h12345,16'hBEEF,1'b1,3'd1,2'd2,4'd4},
    // R8 ignored while busy, then done
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd2,4'd8},
    '{1'b0,1'b1,1'b0,20'h00000,16'h0000,1'b0,3'd0,2'd0,4'd8},
    // R7 identifier entry, R3 reset exit
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd0,4'd7},
    '{1'b1,1'b0,1'b0,20'h002AA,16'h0055,1'b0,3'd0,2'd0,4'd7},
    '{1'b1,1'b0,1'b0,20'h00555,16'h0090,1'b0,3'd0,2'd1,4'd7},
    '{1'b1,1'b0,1'b0,20'h00000,16'h00F0,1'b1,3'd0,2'd0,4'd3},
    // R9 broken pattern
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd0,4'd9},
    '{1'b1,1'b0,1'b0,20'h00123,16'h0055,1'b0,3'd0,2'd0,4'd9},
    '{1'b1,1'b0,1'b0,20'h002AA,16'h0055,1'b0,3'd0,2'd0,4'd9},
    // R5 bypass entry in byte mode
    '{1'b1,1'b0,1'b1,20'h00AAA,16'h00AA,1'b0,3'd0,2'd0,4'd5},
    '{1'b1,1'b0,1'b1,20'h00555,16'h0055,1'b0,3'd0,2'd0,4'd5},
    '{1'b1,1'b0,1'b1,20'h00AAA,16'h0020,1'b0,3'd0,2'd0,4'd5},
    '{1'b1,1'b0,1'b1,20'h00000,16'h00A0,1'b0,3'd0,2'd0,4'd5},
    '{1'b1,1'b0,1'b1,20'h00400,16'h1234,1'b1,3'd1,2'd2,4'd5},
    '{1'b0,1'b1,1'b1,20'h00000,16'h0000,1'b0,3'd0,2'd0,4'd8},
    // R6 F0 ignored in bypass, bypass persists, then exit
    '{1'b1,1'b0,1'b1,20'h00777,16'h00F0,1'b0,3'd0,2'd0,4'd6},
    '{1'b1,1'b0,1'b1,20'h00000,16'h00A0,1'b0,3'd0,2'd0,4'd6},
    '{1'b1,1'b0,1'b1,20'h00010,16'h00FF,1'b1,3'd1,2'd2,4'd6},
    '{1'b0,1'b1,1'b1,20'h00000,16'h0000,1'b0,3'd0,2'd0,4'd8},
    '{1'b1,1'b0,1'b1,20'h00000,16'h0090,1'b0,3'd0,2'd0,4'd6},
    '{1'b1,1'b0,1'b1,20'h00000,16'h0000,1'b0,3'd0,2'd0,4'd6},
    '{1'b1,1'b0,1'b1,20'h00000,16'h00A0,1'b0,3'd0,2'd0,4'd6},
    '{1'b1,1'b0,1'b1,20'h00010,16'h0011,1'b0,3'd0,2'd0,4'd6},
    // R10 sector erase, R11 suspend and resume
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h002AA,16'h0055,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h00555,16'h0080,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h002AA,16'h0055,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h40000,16'h0030,1'b1,3'd3,2'd2,4'd10},
    '{1'b1,1'b0,1'b0,20'h00000,16'h00B0,1'b1,3'd4,2'd0,4'd11},
    '{1'b1,1'b0,1'b0,20'h00000,16'h0030,1'b1,3'd5,2'd2,4'd11},
    '{1'b0,1'b1,1'b0,20'h00000,16'h0000,1'b0,3'd0,2'd0,4'd8},
    // R10 chip erase
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h002AA,16'h0055,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h00555,16'h0080,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h00555,16'h00AA,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h002AA,16'h0055,1'b0,3'd0,2'd0,4'd10},
    '{1'b1,1'b0,1'b0,20'h00555,16'h0010,1'b1,3'd2,2'd2,4'd10},
    '{1'b0,1'b1,1'b0,20'h00000,16'h0000,1'b0,3'd0,2'd0,4'd8},
    // R2 high address bits and high data byte ignored
    '{1'b1,1'b0,1'b0,20'h7D555,16'h12AA,1'b0,3'd0,2'd0,4'd2},
    '{1'b1,1'b0,1'b0,20'h7FAAA,16'hFF55,1'b0,3'd0,2'd0,4'd2},
    '{1'b1,1'b0,1'b0,20'h00555,16'h5590,1'b0,3'd0,2'd1,4'd2},
    '{1'b1,1'b0,1'b0,20'h00000,16'h00F0,1'b1,3'd0,2'd0,4'd3}
  };

  logic          clk;
  logic          rst_n;
  logic          byte_mode;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          op_done;
  logic [2:0]    rd_offs;
  logic          sect_prot;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [1:0]    rd_src;
  logic [DW-1:0] id_rdata;

  int n_chk;
  int n_bad;

  flash_cmd_decoder #(.AW(AW), .DW(DW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_mode (byte_mode),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .op_done   (op_done),
    .rd_offs   (rd_offs),
    .sect_prot (sect_prot),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .rd_src    (rd_src),
    .id_rdata  (id_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write cycle; returns at the negedge after the sampling edge
  task automatic bus_wr(input logic bm, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    byte_mode = bm; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; byte_mode = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    op_done = 1'b0; rd_offs = 3'd0; sect_prot = 1'b0;
    repeat (3) @(negedge clk);
    // R1 state during reset
    check("R1 req during reset", {31'd0, req_valid}, 32'd0);
    check("R1 src during reset", {30'd0, rd_src}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req after reset", {31'd0, req_valid}, 32'd0);
    check("R1 src after reset", {30'd0, rd_src}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        bus_wr(VEC[i].bm, VEC[i].a, VEC[i].d);
      end else begin
        byte_mode = VEC[i].bm;
        pulse_done();
      end
      check($sformatf("R%0d vec%0d req", VEC[i].tag, i), {31'd0, req_valid}, {31'd0, VEC[i].rq});
      if (VEC[i].rq)
        check($sformatf("R%0d vec%0d op", VEC[i].tag, i), {29'd0, req_op}, {29'd0, VEC[i].op});
      check($sformatf("R%0d vec%0d src", VEC[i].tag, i), {30'd0, rd_src}, {30'd0, VEC[i].src});
    end

    // R4 latched address/data, R12 single-cycle request
    bus_wr(1'b0, 20'h00555, 16'h00AA);
    bus_wr(1'b0, 20'h002AA, 16'h0055);
    bus_wr(1'b0, 20'h00555, 16'h00A0);
    bus_wr(1'b0, 20'h0ABCD, 16'h5A5A);
    check("R4 req_addr", {12'd0, req_addr}, 32'h0ABCD);
    check("R4 req_data", {16'd0, req_data}, 32'h5A5A);
    @(negedge clk);
    check("R12 request one cycle", {31'd0, req_valid}, 32'd0);
    pulse_done();
    check("R8 done returns array", {30'd0, rd_src}, 32'd0);

    // R7 identifier data in word and byte modes
    bus_wr(1'b0, 20'h00555, 16'h00AA);
    bus_wr(1'b0, 20'h002AA, 16'h0055);
    bus_wr(1'b0, 20'h00555, 16'h0090);
    check("R7 src id", {30'd0, rd_src}, 32'd1);
    rd_offs = 3'd0; #1;
    check("R7 word maker", {16'd0, id_rdata}, 32'h0052);
    rd_offs = 3'd1; #1;
    check("R7 word device", {16'd0, id_rdata}, 32'h22DA);
    rd_offs = 3'd2; sect_prot = 1'b1; #1;
    check("R7 word protected", {16'd0, id_rdata}, 32'h0001);
    sect_prot = 1'b0; #1;
    check("R7 word unprotected", {16'd0, id_rdata}, 32'h0000);
    byte_mode = 1'b1; rd_offs = 3'd0; #1;
    check("R7 byte maker", {16'd0, id_rdata}, 32'h0052);
    rd_offs = 3'd2; #1;
    check("R7 byte device", {16'd0, id_rdata}, 32'h00DA);
    rd_offs = 3'd4; sect_prot = 1'b1; #1;
    check("R7 byte protected", {16'd0, id_rdata}, 32'h0001);
    bus_wr(1'b1, 20'h00000, 16'h00F0);
    check("R3 id exit", {30'd0, rd_src}, 32'd0);

    // R10 sector address latched
    bus_wr(1'b0, 20'h00555, 16'h00AA);
    bus_wr(1'b0, 20'h002AA, 16'h0055);
    bus_wr(1'b0, 20'h00555, 16'h0080);
    bus_wr(1'b0, 20'h00555, 16'h00AA);
    bus_wr(1'b0, 20'h002AA, 16'h0055);
    bus_wr(1'b0, 20'h6F123, 16'h0030);
    check("R10 sector addr", {12'd0, req_addr}, 32'h6F123);
    // R8 F0 ignored during erase
    bus_wr(1'b0, 20'h00000, 16'h00F0);
    check("R8 F0 during erase req", {31'd0, req_valid}, 32'd0);
    check("R8 F0 during erase src", {30'd0, rd_src}, 32'd2);

    // R1 reset aborts running erase
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R1 async abort", {30'd0, rd_src}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after abort", {30'd0, rd_src}, 32'd0);

    // R6 bypass exit with wrong second byte stays in bypass
    bus_wr(1'b0, 20'h00555, 16'h00AA);
    bus_wr(1'b0, 20'h002AA, 16'h0055);
    bus_wr(1'b0, 20'h00555, 16'h0020);
    bus_wr(1'b0, 20'h00000, 16'h0090);
    bus_wr(1'b0, 20'h00000, 16'h0011);
    bus_wr(1'b0, 20'h00000, 16'h00A0);
    bus_wr(1'b0, 20'h00020, 16'h0077);
    check("R6 bypass kept after bad exit", {31'd0, req_valid}, 32'd1);
    pulse_done();
    do_reset();
    check("R1 reset clears bypass", {30'd0, rd_src}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule